// File: doc/BRIEF.md
# Weighted Modulo-4 Sum Code Checker

This block is a concurrent error-detection checker for a group of six outputs of a combinational unit under test. Four of the outputs form a data vector and two form a check value. The group is a code word when the check value equals the weighted sum of the data bits modulo 4. The weight set can be chosen at run time from four fixed arrays.

In every allowed array the two low data bits can be recovered from the two high data bits and the check value. This makes it possible to apply correction to either of two pairs. Before the check, a selectable pair of signals is XORed with two externally supplied correction functions: either the check bits or the two low data bits.

The checker recomputes the residue and compares it with the check value through a two-rail comparator tree. It drives a two-rail indication combinationally. It also keeps a registered sticky error flag, which records any strobed error until a synchronous reset.

The input is a plain strobe and never back-pressures. A word presented with the strobe high is judged in that same cycle, and no ready signal exists.

Top module: `wsum_mod4_checker`

## Requirements
- R1: A word is valid when `chk_i` equals (sum over the set bits of `data_i` of their weights) mod 4, after correction. `data_i[3]` is the most significant data bit. `wsel_i` picks the weights, listed for bits 3..0: 00 = 1,1,1,2; 01 = 1,1,2,3; 10 = 1,2,2,3; 11 = 2,2,2,3.
- R2: `rail_o` is 01 or 10 for a valid word and 00 or 11 for an invalid word.
- R3: With zero correction, exactly 16 of the 64 six-bit words are accepted for each value of `wsel_i`.
- R4: Inverting any single bit of an accepted word gives an error indication, for every weight array.
- R5: Among the accepted words of one array, each combination of (`data_i[3:2]`, `chk_i`) occurs exactly once.
- R6: With `cmode_i` = 0, `corr_i[1:0]` is XORed into `chk_i[1:0]` only, and the data bits are used as they arrive.
- R7: With `cmode_i` = 1, `corr_i[1:0]` is XORed into `data_i[1:0]` only, and the check bits are used as they arrive.
- R8: `err_o` becomes 1 after a rising clock edge at which `in_valid` is high and `rail_o` shows an error.
- R9: An error indication with `in_valid` low leaves `err_o` unchanged.
- R10: `err_o` is 0 after a clock edge with `rst` high. Once set, it stays set until such an edge.
- R11: `rail_o` depends only on the current inputs, in the same cycle, whatever the value of `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: the word is meaningful this cycle |
| data_i | input | 4 | Data outputs of the unit under test, bit 3 most significant |
| chk_i | input | 2 | Check outputs of the unit under test |
| corr_i | input | 2 | Correction functions XORed into the selected pair |
| wsel_i | input | 2 | Weight array select |
| cmode_i | input | 1 | Correction target: 0 = check bits, 1 = low data bits |
| rail_o | output | 2 | Two-rail indication, 01/10 = valid |
| err_o | output | 1 | Registered sticky error flag |

## Verification
The properties assume that every input has a known value whenever reset is low. The bench meets this by driving all inputs from time zero, always on the falling edge.

The sticky-flag properties assume that the strobe and the word stay constant across each rising edge. The bench holds each word for a full clock period to satisfy this.

The stimulus covers every six-bit word under every array, both correction modes, and all four correction patterns. It also includes deliberate stretches of unstrobed bad words, so that the flag's quiet behaviour is exercised.

// File: rtl/wsum_pkg.sv
package wsum_pkg;
  localparam int DATA_W = 4;
  localparam int CHK_W  = 2;
  localparam int SEL_W  = 2;
  localparam int FIX_W  = 2;

  typedef logic [CHK_W-1:0] resid_t;

  // weight of data bit idx (idx 3 is the most significant) under array sel
  function automatic resid_t bit_weight(input logic [SEL_W-1:0] sel, input int idx);
    resid_t w;
    case (idx)
      3:       w = (sel == 2'd3) ? 2'd2 : 2'd1;
      2:       w = sel[1] ? 2'd2 : 2'd1;
      1:       w = (sel == 2'd0) ? 2'd1 : 2'd2;
      default: w = (sel == 2'd0) ? 2'd2 : 2'd3;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/wsum_corrector.sv
module wsum_corrector
  import wsum_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic [FIX_W-1:0]  fix_i,
  input  logic              mode_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    if (i < FIX_W) begin : g_fix
      assign data_o[i] = data_i[i] ^ (fix_i[i] & mode_i);
    end else begin : g_pass
      assign data_o[i] = data_i[i];
    end
  end

  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    if (j < FIX_W) begin : g_fix
      assign chk_o[j] = chk_i[j] ^ (fix_i[j] & ~mode_i);
    end else begin : g_pass
      assign chk_o[j] = chk_i[j];
    end
  end
endmodule

// File: rtl/wsum_residue.sv
module wsum_residue
  import wsum_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output resid_t            res_o
);
  always_comb begin
    res_o = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (data_i[k]) res_o = res_o + bit_weight(sel_i, k);
    end
  end
endmodule

// File: rtl/tworail_cell.sv
module tworail_cell (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [1:0] y_o
);
  assign y_o[1] = (a_i[1] & b_i[1]) | (a_i[0] & b_i[0]);
  assign y_o[0] = (a_i[1] & b_i[0]) | (a_i[0] & b_i[1]);
endmodule

// File: rtl/wsum_mod4_checker.sv
module wsum_mod4_checker
  import wsum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic [FIX_W-1:0]  corr_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic              cmode_i,
  output logic [1:0]        rail_o,
  output logic              err_o
);
  logic [DATA_W-1:0] data_c;
  resid_t            chk_c;
  resid_t            res;
  logic [1:0]        pair [CHK_W];
  logic [1:0]        acc  [CHK_W];
  logic              bad;

  wsum_corrector u_fix (
    .data_i(data_i), .chk_i(chk_i), .fix_i(corr_i), .mode_i(cmode_i),
    .data_o(data_c), .chk_o(chk_c)
  );

  wsum_residue u_res (.data_i(data_c), .sel_i(wsel_i), .res_o(res));

  // one two-rail pair per check bit: rails differ when residue bit matches
  for (genvar i = 0; i < CHK_W; i++) begin : g_pair
    assign pair[i] = {res[i], ~chk_c[i]};
  end

  assign acc[0] = pair[0];
  for (genvar i = 1; i < CHK_W; i++) begin : g_tree
    tworail_cell u_cell (.a_i(acc[i-1]), .b_i(pair[i]), .y_o(acc[i]));
  end

  assign rail_o = acc[CHK_W-1];
  assign bad    = ~(rail_o[1] ^ rail_o[0]);

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else if (in_valid && bad) err_o <= 1'b1;
  end

  p_rail_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (res == chk_c) |-> (rail_o[1] ^ rail_o[0]));
  p_rail_error_r2: assert property (@(posedge clk) disable iff (rst)
    (res != chk_c) |-> !(rail_o[1] ^ rail_o[0]));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (rail_o == 2'b00 || rail_o == 2'b11)) |=> err_o);
  p_flag_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !(in_valid && (rail_o == 2'b00 || rail_o == 2'b11))) |=> !err_o);
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: tb/wsum_mod4_checker_test.sv
module wsum_mod4_checker_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] data_i = '0;
  logic [1:0] chk_i = '0;
  logic [1:0] corr_i = '0;
  logic [1:0] wsel_i = '0;
  logic       cmode_i = 1'b0;
  logic [1:0] rail_o;
  logic       err_o;

  always #10 clk = ~clk;

  wsum_mod4_checker uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_i(data_i), .chk_i(chk_i),
    .corr_i(corr_i), .wsel_i(wsel_i), .cmode_i(cmode_i), .rail_o(rail_o), .err_o(err_o)
  );

  typedef struct {
    bit         exp_ok;
    bit         exp_flag;
    bit         sweep;
    logic [1:0] w;
    logic [3:0] d;
    logic [1:0] c;
    string      tag;
  } item_t;

  item_t q[$];
  int  checks = 0;
  int  fails = 0;
  bit  model_flag = 1'b0;
  bit  done = 1'b0;
  int  acc_cnt [4];
  int  seen [4][4][4];

  // weights written from the requirement R1 table
  function automatic int wt(input logic [1:0] s, input int idx);
    int tbl [4][4];
    tbl[0] = '{2, 1, 1, 1};
    tbl[1] = '{3, 2, 1, 1};
    tbl[2] = '{3, 2, 2, 1};
    tbl[3] = '{3, 2, 2, 2};
    return tbl[s][idx];
  endfunction

  function automatic bit is_code(input logic [1:0] s, input logic [3:0] d, input logic [1:0] c);
    int sum = 0;
    for (int k = 0; k < 4; k++) if (d[k]) sum += wt(s, k);
    return (sum % 4) == int'(c);
  endfunction

  task automatic drive(input logic r, input logic v, input logic [3:0] d, input logic [1:0] c,
                       input logic [1:0] f, input logic [1:0] s, input logic m,
                       input bit sw, input string tag);
    item_t it;
    logic [3:0] dc;
    logic [1:0] cc;
    @(negedge clk);
    rst = r; in_valid = v; data_i = d; chk_i = c; corr_i = f; wsel_i = s; cmode_i = m;
    dc = m ? {d[3:2], d[1:0] ^ f} : d;
    cc = m ? c : c ^ f;
    it.exp_ok = is_code(s, dc, cc);
    it.exp_flag = model_flag;
    it.sweep = sw; it.w = s; it.d = d; it.c = c; it.tag = tag;
    q.push_back(it);
    model_flag = r ? 1'b0 : (model_flag | (v & ~it.exp_ok));
  endtask

  // monitor: compares each queued expectation shortly after it was driven
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        bit got_ok;
        it = q.pop_front();
        got_ok = rail_o[1] ^ rail_o[0];
        checks++;
        if (got_ok !== it.exp_ok || err_o !== it.exp_flag) begin
          fails++;
          $display("FAIL %s: rail=%b ok=%0b flag=%0b, expected ok=%0b flag=%0b (w=%0d d=%b c=%b)",
                   it.tag, rail_o, got_ok, err_o, it.exp_ok, it.exp_flag, it.w, it.d, it.c);
        end
        if (it.sweep && got_ok) begin
          acc_cnt[it.w]++;
          seen[it.w][it.d[3:2]][it.c]++;
        end
      end
    end
  end

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      acc_cnt[s] = 0;
      for (int h = 0; h < 4; h++) for (int c = 0; c < 4; c++) seen[s][h][c] = 0;
    end

    // R10: reset state, flag clear
    drive(1, 0, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R10 reset");
    drive(0, 0, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R10 after reset");

    // R9 and R11: bad words unstrobed; the indication still shows the error
    drive(0, 0, 4'h1, 2'h0, 2'h0, 2'h0, 0, 0, "R9 unstrobed bad");
    drive(0, 0, 4'hF, 2'h0, 2'h0, 2'h3, 0, 0, "R11 unstrobed bad");
    drive(0, 0, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R9 flag still clear");

    // R1 R2 R3 R5: exhaustive sweep, no correction, strobe low to keep the flag clear
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 64; w++)
        drive(0, 0, w[5:2], w[1:0], 2'h0, s[1:0], w[0], 1, "R1 R2 sweep");
    settle();
    for (int s = 0; s < 4; s++) begin
      checks++;
      if (acc_cnt[s] != 16) begin
        fails++;
        $display("FAIL R3: array %0d accepted %0d, expected 16", s, acc_cnt[s]);
      end
      for (int h = 0; h < 4; h++) for (int c = 0; c < 4; c++) begin
        checks++;
        if (seen[s][h][c] != 1) begin
          fails++;
          $display("FAIL R5: array %0d hi=%0d chk=%0d seen %0d, expected 1", s, h, c, seen[s][h][c]);
        end
      end
    end

    // R4: single-bit flips of every code word
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 64; w++)
        if (is_code(s[1:0], w[5:2], w[1:0]))
          for (int b = 0; b < 6; b++) begin
            logic [5:0] x;
            x = w[5:0] ^ (6'd1 << b);
            drive(0, 0, x[5:2], x[1:0], 2'h0, s[1:0], 0, 0, "R4 single flip");
          end

    // R6 R7: every correction pattern in both modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int f = 1; f < 4; f++)
          for (int w = 0; w < 64; w++)
            drive(0, 0, w[5:2], w[1:0], f[1:0], s[1:0], m[0], 0, m ? "R7 low data fix" : "R6 check fix");

    // R8: strobed good words keep the flag clear, then one strobed bad word sets it
    drive(0, 1, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R8 good strobed");
    drive(0, 1, 4'h8, 2'h1, 2'h0, 2'h0, 0, 0, "R8 good strobed");
    drive(0, 1, 4'h8, 2'h2, 2'h0, 2'h0, 0, 0, "R8 bad strobed");
    drive(0, 1, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R8 flag set");
    // R10: hold across good words, then clear by reset
    drive(0, 1, 4'h1, 2'h3, 2'h0, 2'h1, 0, 0, "R10 hold");
    drive(0, 0, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R10 hold");
    drive(1, 1, 4'h1, 2'h0, 2'h0, 2'h0, 0, 0, "R10 reset with bad");
    drive(0, 0, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R10 cleared");
    drive(0, 0, 4'h0, 2'h0, 2'h0, 2'h0, 0, 0, "R10 cleared");
    settle();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule